// File: doc/BRIEF.md
# Complementary PWM Output Guard with Dead Time and Fault Override

This block sits between a multi-channel PWM generator and the pins that drive a power stage. For the first two channels, which drive the two switches of a half bridge, it can hold back the turn-on of each switch by a programmable number of clock cycles. Turn-off is never delayed. Both switches are then never on together. The remaining channels pass straight through.

A fault input can force the outputs to a stored safe pattern. The fault can come from an external pin or from an on-chip comparator. Its active level is programmable, and detection can be level or edge based. The selected fault signal is synchronised to the clock and latched in a flag. While the flag is set, every enabled channel shows its pattern bit. A per-channel enable gates every pin, so a disabled channel is always low.

Top module: `pwm_guard`

## Requirements
- R1: With the dead-time value N not 0, pwm_o[0] goes high exactly N clock edges after pwm_raw_i[0] rises. pwm_o[1] is driven from the inverse of pwm_raw_i[0] and goes high exactly N clock edges after pwm_raw_i[0] falls.
- R2: With N not 0, a channel 0 or 1 output drops in the same cycle as its source, with no added delay.
- R3: With N not 0 and no fault latched, pwm_o[0] and pwm_o[1] are never high together.
- R4: With N = 0, pwm_o[0] and pwm_o[1] follow pwm_raw_i[0] and pwm_raw_i[1] directly. With N not 0, pwm_raw_i[1] has no effect on any output.
- R5: Channels 2 and above follow their raw inputs with no delay when no fault is latched.
- R6: A channel whose bit in cfg_oe_i is 0 drives 0 at all times, including during reset and while a fault is latched.
- R7: cfg_brk_src_i = 0 selects brk_pin_i and cfg_brk_src_i = 1 selects brk_cmp_i as the fault source. The unselected source has no effect.
- R8: cfg_brk_pol_i = 1 makes the fault active when the selected source is high. cfg_brk_pol_i = 0 makes it active when the source is low.
- R9: The fault condition passes through two synchronising flops. In level mode (cfg_brk_edge_i = 0) the flag sets while the synchronised condition is active, three clock edges after the source changes. In edge mode (cfg_brk_edge_i = 1) the flag sets only on an inactive-to-active change of the synchronised condition.
- R10: While brk_flag_o is 1, each enabled channel drives its bit of cfg_brk_pat_i. The flag holds until brk_clr_i is sampled high. In level mode that clear is ignored while the synchronised condition is still active. In edge mode the clear takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_raw_i | input | 4 | Raw PWM signals from the generator |
| brk_pin_i | input | 1 | External fault pin |
| brk_cmp_i | input | 1 | Internal comparator output used as a fault source |
| cfg_dead_i | input | 8 | Dead time in clock cycles, 0 disables insertion |
| cfg_brk_src_i | input | 1 | Fault source select: 0 pin, 1 comparator |
| cfg_brk_pol_i | input | 1 | Fault active level: 1 high, 0 low |
| cfg_brk_edge_i | input | 1 | Fault detection: 0 level, 1 edge |
| cfg_brk_pat_i | input | 4 | Output values forced while the fault is latched |
| cfg_oe_i | input | 4 | Per-channel output enable |
| brk_clr_i | input | 1 | Request to clear the fault flag |
| pwm_o | output | 4 | Final PWM pins |
| brk_flag_o | output | 1 | Latched fault status |

## Verification
The bench drives channel 0 with pulses both shorter and longer than the dead time, at the smallest and largest non-zero values. A design that delayed falling edges, or that let a short pulse leak through, would then show an overlap or a wrong pulse width. It toggles pwm_raw_i[1] and the unselected fault source while they should be ignored, which exposes a wrong multiplexer. It tries a clear while a level fault is still active, and another in edge mode. A flag that dropped early, or that could never be cleared in edge mode, would show up there. A single fixed fault latency of three edges is also checked, so a missing or extra synchronising stage shifts the flag and fails.

// File: rtl/pwm_guard_pkg.sv
package pwm_guard_pkg;

  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_CMP = 1'b1
  } brk_src_e;

  typedef enum logic {
    DET_LEVEL = 1'b0,
    DET_EDGE  = 1'b1
  } brk_det_e;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/pwm_guard_brk.sv
module pwm_guard_brk
  import pwm_guard_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic cmp_i,
  input  logic src_i,
  input  logic pol_i,
  input  logic det_i,
  input  logic clr_i,
  output logic flag_o
);

  brk_src_e src;
  brk_det_e det;
  logic     sel;
  logic     act;
  logic     synced;
  logic     hit;
  logic     clr_ok;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   hist_q;
  logic                   flag_q, flag_d, flag_en;

  assign src = brk_src_e'(src_i);
  assign det = brk_det_e'(det_i);

  // source select and polarity
  always_comb begin
    sel = (src == SRC_CMP) ? cmp_i : pin_i;
    act = pol_i ? sel : ~sel;
  end

  // synchroniser shift
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], act};
    end else begin : g_single
      assign sync_d = act;
    end
  endgenerate

  assign synced = sync_q[SYNC_STAGES-1];

  // detection and flag next state
  always_comb begin
    hit     = (det == DET_EDGE) ? (synced & ~hist_q) : synced;
    clr_ok  = clr_i & ((det == DET_EDGE) | ~synced);
    flag_d  = hit | (flag_q & ~clr_ok);
    flag_en = hit | (flag_q & clr_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= synced;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/pwm_guard_dead.sv
module pwm_guard_dead #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            src_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            out_o
);

  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;
  logic            ready;

  // count consecutive high cycles of the source, saturating at dt_i
  always_comb begin
    ready = (cnt_q >= dt_i);
    if (src_i) begin
      cnt_en = ~ready;
      cnt_d  = cnt_q + 1'b1;
    end else begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // rise waits for the count, fall is immediate
  assign out_o = src_i & ready;

endmodule

// File: rtl/pwm_guard_out.sv
module pwm_guard_out #(
  parameter int unsigned CH = 4
) (
  input  logic [CH-1:0] shaped_i,
  input  logic [CH-1:0] oe_i,
  input  logic [CH-1:0] pat_i,
  input  logic          flag_i,
  output logic [CH-1:0] pwm_o
);

  generate
    for (genvar g = 0; g < CH; g++) begin : g_ch
      always_comb begin
        if (!oe_i[g]) begin
          pwm_o[g] = 1'b0;
        end else if (flag_i) begin
          pwm_o[g] = pat_i[g];
        end else begin
          pwm_o[g] = shaped_i[g];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pwm_guard.sv
module pwm_guard #(
  parameter int unsigned CH   = 4,
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CH-1:0]   pwm_raw_i,
  input  logic            brk_pin_i,
  input  logic            brk_cmp_i,
  input  logic [DT_W-1:0] cfg_dead_i,
  input  logic            cfg_brk_src_i,
  input  logic            cfg_brk_pol_i,
  input  logic            cfg_brk_edge_i,
  input  logic [CH-1:0]   cfg_brk_pat_i,
  input  logic [CH-1:0]   cfg_oe_i,
  input  logic            brk_clr_i,
  output logic [CH-1:0]   pwm_o,
  output logic            brk_flag_o
);

  localparam int unsigned PAIR = 2;

  logic [1:0]      rst_q;
  logic            rst_int_n;
  logic            dt_on;
  logic [PAIR-1:0] pair_src;
  logic [PAIR-1:0] pair_dly;
  logic [CH-1:0]   shaped;
  logic            flag;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_q[1];

  assign dt_on = (cfg_dead_i != '0);

  // complementary pair both derived from channel 0
  assign pair_src[0] = pwm_raw_i[0];
  assign pair_src[1] = ~pwm_raw_i[0];

  generate
    for (genvar g = 0; g < PAIR; g++) begin : g_pair
      pwm_guard_dead #(.DT_W(DT_W)) u_dead (
        .clk_i  (clk_i),
        .rst_ni (rst_int_n),
        .src_i  (pair_src[g]),
        .dt_i   (cfg_dead_i),
        .out_o  (pair_dly[g])
      );
      assign shaped[g] = dt_on ? pair_dly[g] : pwm_raw_i[g];
    end
    for (genvar g = PAIR; g < CH; g++) begin : g_thru
      assign shaped[g] = pwm_raw_i[g];
    end
  endgenerate

  pwm_guard_brk u_brk (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .pin_i  (brk_pin_i),
    .cmp_i  (brk_cmp_i),
    .src_i  (cfg_brk_src_i),
    .pol_i  (cfg_brk_pol_i),
    .det_i  (cfg_brk_edge_i),
    .clr_i  (brk_clr_i),
    .flag_o (flag)
  );

  pwm_guard_out #(.CH(CH)) u_out (
    .shaped_i (shaped),
    .oe_i     (cfg_oe_i),
    .pat_i    (cfg_brk_pat_i),
    .flag_i   (flag),
    .pwm_o    (pwm_o)
  );

  assign brk_flag_o = flag;

endmodule

// File: rtl/pwm_guard_chk.sv
module pwm_guard_chk #(
  parameter int unsigned CH   = 4,
  parameter int unsigned DT_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [CH-1:0]   pwm_raw_i,
  input logic [DT_W-1:0] cfg_dead_i,
  input logic [CH-1:0]   cfg_brk_pat_i,
  input logic [CH-1:0]   cfg_oe_i,
  input logic            brk_clr_i,
  input logic [CH-1:0]   pwm_o,
  input logic            brk_flag_o
);

  assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_dead_i != '0 && !brk_flag_o) |-> !(pwm_o[0] && pwm_o[1]));

  assert_fall_now_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_dead_i != '0 && !brk_flag_o && !pwm_raw_i[0]) |-> !pwm_o[0]);

  assert_thru_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brk_flag_o |-> (pwm_o[CH-1:2] == (pwm_raw_i[CH-1:2] & cfg_oe_i[CH-1:2])));

  assert_oe_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> ((pwm_o & ~cfg_oe_i) == '0));

  assert_pattern_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_flag_o |-> (pwm_o == (cfg_brk_pat_i & cfg_oe_i)));

  assert_flag_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_flag_o && !brk_clr_i) |=> brk_flag_o);

endmodule

bind pwm_guard pwm_guard_chk #(.CH(CH), .DT_W(DT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pwm_raw_i     (pwm_raw_i),
  .cfg_dead_i    (cfg_dead_i),
  .cfg_brk_pat_i (cfg_brk_pat_i),
  .cfg_oe_i      (cfg_oe_i),
  .brk_clr_i     (brk_clr_i),
  .pwm_o         (pwm_o),
  .brk_flag_o    (brk_flag_o)
);

// File: tb/test_pwm_guard.sv
`timescale 1ns/1ps
module test_pwm_guard;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] raw;
  logic       brk_pin, brk_cmp;
  logic [7:0] dead;
  logic       brk_src, brk_pol, brk_edge, brk_clr;
  logic [3:0] pat, oe;
  logic [3:0] pwm;
  logic       flag;

  int tests = 0;
  int fails = 0;
  bit run_chk = 1'b0;
  string tag = "R6";

  always #4 clk = ~clk;

  pwm_guard i_pwm_guard (
    .clk_i(clk), .rst_ni(rst_n), .pwm_raw_i(raw),
    .brk_pin_i(brk_pin), .brk_cmp_i(brk_cmp), .cfg_dead_i(dead),
    .cfg_brk_src_i(brk_src), .cfg_brk_pol_i(brk_pol), .cfg_brk_edge_i(brk_edge),
    .cfg_brk_pat_i(pat), .cfg_oe_i(oe), .brk_clr_i(brk_clr),
    .pwm_o(pwm), .brk_flag_o(flag)
  );

  // behavioural reference model
  int m_rel, m_s1, m_s2, m_s3, m_flag, m_c0, m_c1;

  always @(posedge clk) begin
    int sel, act, det, clr_ok;
    if (!rst_n || m_rel < 2) begin
      m_rel = rst_n ? m_rel + 1 : 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_flag = 0; m_c0 = 0; m_c1 = 0;
    end else begin
      sel    = brk_src ? int'(brk_cmp) : int'(brk_pin);
      act    = brk_pol ? sel : (sel == 0 ? 1 : 0);
      det    = brk_edge ? ((m_s2 != 0 && m_s3 == 0) ? 1 : 0) : m_s2;
      clr_ok = (brk_clr && (brk_edge || m_s2 == 0)) ? 1 : 0;
      m_flag = (det != 0 || (m_flag != 0 && clr_ok == 0)) ? 1 : 0;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = act;
      if (raw[0]) begin if (m_c0 < int'(dead)) m_c0++; end else m_c0 = 0;
      if (!raw[0]) begin if (m_c1 < int'(dead)) m_c1++; end else m_c1 = 0;
    end
  end

  function automatic logic [3:0] expect_pwm();
    logic [3:0] e;
    if (dead == 0) begin
      e[1:0] = raw[1:0];
    end else begin
      e[0] = raw[0] && (m_c0 >= int'(dead));
      e[1] = !raw[0] && (m_c1 >= int'(dead));
    end
    e[3:2] = raw[3:2];
    if (m_flag != 0) e = pat;
    return e & oe;
  endfunction

  always @(negedge clk) begin
    if (run_chk) begin
      logic [3:0] e;
      e = expect_pwm();
      tests++;
      if (pwm !== e || flag !== (m_flag != 0)) begin
        fails++;
        $display("FAIL %s cycle check: pwm=%b flag=%b expected pwm=%b flag=%0d",
                 tag, pwm, flag, e, m_flag);
      end
    end
  end

  task automatic check(string t, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  // count negedges until the selected condition, from just after an edge
  task automatic wait_rise(int which, output int n);
    n = 0;
    while (n < 400 && ((which == 0) ? !pwm[0] : !flag)) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    int n;
    rst_n = 1'b0; raw = '0; brk_pin = 1'b0; brk_cmp = 1'b0; dead = '0;
    brk_src = 1'b0; brk_pol = 1'b1; brk_edge = 1'b0; brk_clr = 1'b0;
    pat = '0; oe = '0;
    tick(3);
    raw = 4'hF; oe = 4'b0000; #1;
    check("R6 reset pwm", int'(pwm), 0);
    check("R10 reset flag", int'(flag), 0);
    run_chk = 1'b1;
    tick(1);
    rst_n = 1'b1;
    tick(4);

    // R6: partial enables
    tag = "R6"; oe = 4'b0101;
    for (int i = 0; i < 16; i++) begin raw = 4'(i); tick(1); end

    // R4 R5: no dead time, straight pass
    tag = "R4 R5"; oe = 4'hF;
    for (int i = 0; i < 16; i++) begin raw = 4'(i * 5); tick(1); end

    // R1 R2 R3: pulses around the dead time, raw1 toggled to show it is ignored (R4)
    tag = "R1 R2 R3 R4"; dead = 8'd5;
    for (int k = 0; k < 24; k++) begin
      raw[0] = k[0];
      raw[1] = k[1];
      raw[3:2] = 2'(k);
      tick((k * 7) % 13 + 1);
    end

    // R1 explicit delay measurements
    tag = "R1"; raw = 4'b0000; tick(8);
    check("R1 pwm1 high before rise", int'(pwm[1]), 1);
    raw[0] = 1'b1; #1;
    check("R2 pwm1 drops at once", int'(pwm[1]), 0);
    wait_rise(0, n);
    check("R1 rise delay dead=5", n, 6);
    dead = 8'd1; raw[0] = 1'b0; tick(4); raw[0] = 1'b1;
    wait_rise(0, n);
    check("R1 rise delay dead=1", n, 2);

    // R3 largest dead time
    tag = "R1 R3"; dead = 8'd255;
    raw[0] = 1'b0; tick(300); raw[0] = 1'b1; tick(300); raw[0] = 1'b0; tick(20);

    // R7 R10: source select, clear rules in level mode
    tag = "R7 R10"; dead = 8'd3; oe = 4'b1011; pat = 4'b0110;
    brk_src = 1'b0; brk_pol = 1'b1; brk_edge = 1'b0;
    raw = 4'b1101; tick(6);
    brk_cmp = 1'b1; tick(10);
    check("R7 unselected comparator ignored", int'(flag), 0);
    brk_cmp = 1'b0; brk_pin = 1'b1;
    wait_rise(1, n);
    check("R9 level latency", n, 4);
    tick(3);
    brk_clr = 1'b1; tick(1); brk_clr = 1'b0; tick(2);
    check("R10 clear ignored while active", int'(flag), 1);
    check("R10 pattern on enabled channels", int'(pwm), 4'b0010);
    brk_pin = 1'b0; tick(5);
    check("R10 flag held after source inactive", int'(flag), 1);
    brk_clr = 1'b1; tick(1); brk_clr = 1'b0; tick(1);
    check("R10 clear takes effect", int'(flag), 0);
    brk_src = 1'b1; brk_pin = 1'b1; tick(8);
    check("R7 unselected pin ignored", int'(flag), 0);
    brk_pin = 1'b0; brk_cmp = 1'b1; tick(6);
    check("R7 comparator source", int'(flag), 1);
    brk_cmp = 1'b0; tick(4); brk_clr = 1'b1; tick(1); brk_clr = 1'b0; tick(3);

    // R8: active low
    tag = "R8"; brk_src = 1'b0; brk_pin = 1'b1; brk_pol = 1'b0; tick(8);
    check("R8 high is inactive when active low", int'(flag), 0);
    brk_pin = 1'b0; tick(5); brk_pin = 1'b1;
    check("R8 low triggers", int'(flag), 1);
    tick(4); brk_clr = 1'b1; tick(1); brk_clr = 1'b0; tick(3);

    // R9: edge mode
    tag = "R9 R10"; brk_pol = 1'b1; brk_edge = 1'b1; brk_pin = 1'b0; tick(4);
    brk_pin = 1'b1; tick(5);
    check("R9 edge sets flag", int'(flag), 1);
    brk_clr = 1'b1; tick(1); brk_clr = 1'b0; tick(10);
    check("R9 edge mode clear while held", int'(flag), 0);
    brk_pin = 1'b0; tick(4); brk_pin = 1'b1; tick(5);
    check("R9 new edge sets again", int'(flag), 1);
    brk_edge = 1'b0; brk_clr = 1'b1; tick(1); brk_clr = 1'b0; tick(3);
    check("R9 level mode holds while active", int'(flag), 1);
    brk_pin = 1'b0; tick(4); brk_clr = 1'b1; tick(1); brk_clr = 1'b0; tick(4);

    run_chk = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule